// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit sits next to a simple load/store core and decides when normal execution is diverted. It holds three software-visible registers: a status register with a global interrupt enable and a saved copy of it, a cause register that holds a 4-bit reason code and shows the pending device lines, and a return-address register. When an overflow trap or an enabled device interrupt is accepted, the unit saves a return address and records the reason. It also moves the enable bit into the saved copy, clears the enable, and tells the core to fetch next from one fixed handler address. A return input restores the enable and sends fetch back to the saved address.

Device request lines are asynchronous. Each line passes through a two-flop synchronizer. An interrupt is accepted only in a cycle where the core reports a completed instruction, so it always falls between instructions and never cancels the one in flight. The core moves data to and from the registers through a combinational read port and a single-cycle write port. The core-side pins are plain control signals. No stream carries back-pressure, because every event is accepted in the cycle it is presented.

Top module: `exc_ctrl_top`

## Requirements
- R1: After reset, status, the cause code and the return address all read as zero, and `redirect_valid` is low.
- R2: Each `irq_async` line reaches cause bits 15:8 after exactly two rising clock edges. The bits follow the synchronized lines and are never latched, so a line that drops clears its bit.
- R3: An interrupt is accepted only when status bit 0 (enable) is 1, at least one synchronized line is high, and `instr_valid` is high in that cycle. Otherwise no redirect occurs.
- R4: On an accepted interrupt, the return address becomes `next_pc` and the cause code (cause bits 5:2) becomes 0.
- R5: When `instr_valid` and `trap_ovf` are both high, a trap is accepted whatever the enable is. The return address becomes `instr_pc` and the cause code becomes 12. A trap wins over an interrupt in the same cycle.
- R6: On any accepted trap or interrupt, status bit 1 (saved enable) takes the old enable and status bit 0 clears. In the next cycle `redirect_valid` is high with `redirect_pc` = 0x80000080.
- R7: When `eret` is high and no trap is accepted, the enable takes the saved-enable value. In the next cycle `redirect_valid` is high with `redirect_pc` equal to the return address.
- R8: Register numbers are 12 for status (bit 0 enable, bit 1 saved enable), 13 for cause and 14 for the return address. Reads are combinational and any other number reads zero. Writes to 13 are ignored.
- R9: A software write in the same cycle as an accepted trap, interrupt or return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_async | input | 8 | Asynchronous device request lines |
| instr_valid | input | 1 | An instruction completes this cycle |
| instr_pc | input | 32 | Address of the completing instruction |
| next_pc | input | 32 | Address of the next, not yet executed, instruction |
| trap_ovf | input | 1 | Completing instruction overflowed |
| eret | input | 1 | Return from handler |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Register number to write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 5 | Register number to read |
| reg_rd_data | output | 32 | Read data |
| redirect_valid | output | 1 | Force fetch address this cycle |
| redirect_pc | output | 32 | Forced fetch address |

## Verification
A wrong enable or saved-enable bit appears at the ports as a missing or extra redirect on the next completed instruction while a line is pending. It also shows in the status read at once. A corrupted return address or cause code can be read back in the cycle after entry, and it appears in `redirect_pc` one cycle after the next return. Synchronizer depth errors show as the cause's pending byte changing one edge too early or too late.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [4:0] REG_STATUS = 5'd12;
  localparam logic [4:0] REG_CAUSE  = 5'd13;
  localparam logic [4:0] REG_EPC    = 5'd14;

  typedef enum logic [3:0] {
    CODE_INT = 4'd0,
    CODE_OVF = 4'd12
  } exc_code_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_TRAP,
    EV_INT,
    EV_RET
  } exc_ev_e;
endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
  parameter int NIRQ   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  output logic [NIRQ-1:0] irq_out
);
  logic [NIRQ-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= irq_in;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign irq_out = stg[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic    instr_valid,
  input  logic    trap_ovf,
  input  logic    eret,
  input  logic    ie,
  input  logic    irq_pend,
  output exc_ev_e ev
);
  always_comb begin
    if (instr_valid && trap_ovf)           ev = EV_TRAP;
    else if (eret)                         ev = EV_RET;
    else if (instr_valid && ie && irq_pend) ev = EV_INT;
    else                                   ev = EV_NONE;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  exc_ev_e         ev,
  input  logic [XLEN-1:0] instr_pc,
  input  logic [XLEN-1:0] next_pc,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [4:0]      rd_addr,
  input  logic [NIRQ-1:0] irq_lines,
  output logic [XLEN-1:0] rd_data,
  output logic            ie,
  output logic [XLEN-1:0] epc
);
  logic      pie;
  exc_code_e code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      pie  <= 1'b0;
      epc  <= '0;
      code <= CODE_INT;
    end else begin
      unique case (ev)
        EV_TRAP: begin
          epc  <= instr_pc;
          code <= CODE_OVF;
          pie  <= ie;
          ie   <= 1'b0;
        end
        EV_INT: begin
          epc  <= next_pc;
          code <= CODE_INT;
          pie  <= ie;
          ie   <= 1'b0;
        end
        EV_RET: ie <= pie;
        default: begin
          if (wr_en && wr_addr == REG_STATUS) begin
            ie  <= wr_data[0];
            pie <= wr_data[1];
          end else if (wr_en && wr_addr == REG_EPC) begin
            epc <= wr_data;
          end
        end
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      REG_STATUS: rd_data[1:0] = {pie, ie};
      REG_CAUSE: begin
        rd_data[5:2]       = code;
        rd_data[8 +: NIRQ] = irq_lines;
      end
      REG_EPC: rd_data = epc;
      default: rd_data = '0;
    endcase
  end

  // R6: entry saves enable and clears it
  p_enable_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP || ev == EV_INT) |=> (!ie && pie == $past(ie)));
  // R5: trap records faulting address and overflow code
  p_trap_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_TRAP |=> (code == CODE_OVF && epc == $past(instr_pc)));
  // R4: interrupt records next address and code zero
  p_int_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_INT |=> (code == CODE_INT && epc == $past(next_pc)));
  // R8: cause code is not writable
  p_cause_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE && wr_en && wr_addr == REG_CAUSE) |=> $stable(code));
  // R7: return restores enable from saved copy
  p_ret_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_RET |=> ie == $past(pie));
endmodule

// File: rtl/exc_ctrl_top.sv
module exc_ctrl_top
  import exc_pkg::*;
#(
  parameter int              XLEN   = 32,
  parameter int              NIRQ   = 8,
  parameter int              SYNC   = 2,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_async,
  input  logic            instr_valid,
  input  logic [XLEN-1:0] instr_pc,
  input  logic [XLEN-1:0] next_pc,
  input  logic            trap_ovf,
  input  logic            eret,
  input  logic            reg_wr_en,
  input  logic [4:0]      reg_wr_addr,
  input  logic [XLEN-1:0] reg_wr_data,
  input  logic [4:0]      reg_rd_addr,
  output logic [XLEN-1:0] reg_rd_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  logic [NIRQ-1:0] irq_sync;
  logic            ie;
  logic [XLEN-1:0] epc;
  exc_ev_e         ev;

  exc_irq_sync #(.NIRQ(NIRQ), .STAGES(SYNC)) sync_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_async), .irq_out(irq_sync)
  );

  exc_arbiter arb_i (
    .instr_valid(instr_valid), .trap_ovf(trap_ovf), .eret(eret),
    .ie(ie), .irq_pend(|irq_sync), .ev(ev)
  );

  exc_regs #(.XLEN(XLEN), .NIRQ(NIRQ)) regs_i (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .instr_pc(instr_pc), .next_pc(next_pc),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .irq_lines(irq_sync),
    .rd_data(reg_rd_data), .ie(ie), .epc(epc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= (ev != EV_NONE);
      redirect_pc    <= (ev == EV_RET) ? epc : VECTOR;
    end
  end

  // R6: entry vectors to the fixed handler address next cycle
  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP || ev == EV_INT) |=> (redirect_valid && redirect_pc == VECTOR));
  // R7: return goes to the saved address
  p_ret_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_RET |=> (redirect_valid && redirect_pc == $past(epc)));
  // R3: no interrupt redirect without an instruction boundary
  p_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !eret) |=> !redirect_valid);
endmodule

// File: tb/exc_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_async = '0;
  logic        instr_valid = 1'b0, trap_ovf = 1'b0, eret = 1'b0;
  logic [31:0] instr_pc = '0, next_pc = '0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_wr_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  localparam logic [31:0] VEC = 32'h8000_0080;

  always #10 clk = ~clk;

  exc_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_async(irq_async), .instr_valid(instr_valid),
    .instr_pc(instr_pc), .next_pc(next_pc), .trap_ovf(trap_ovf), .eret(eret),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input string req, input logic [31:0] exp);
    reg_rd_addr = a;
    #1 chk(req, reg_rd_data, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // one completed instruction; expected redirect pushed by caller
  task automatic retire(input logic [31:0] pc, input logic ovf);
    @(negedge clk);
    instr_valid = 1'b1; instr_pc = pc; next_pc = pc + 32'd4; trap_ovf = ovf;
    @(negedge clk);
    instr_valid = 1'b0; trap_ovf = 1'b0;
  endtask

  task automatic do_eret();
    @(negedge clk);
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
  endtask

  // monitor: every redirect must match the next queued expectation
  always @(negedge clk) begin
    if (rst_n && redirect_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3 unexpected redirect got=%h exp=none", redirect_pc);
      end else begin
        chk("R6/R7 redirect target", redirect_pc, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 redirect_valid", {31'b0, redirect_valid}, 32'd0);
    rd(5'd12, "R1 status", 32'd0);
    rd(5'd13, "R1 cause", 32'd0);
    rd(5'd14, "R1 epc", 32'd0);

    // R2 and R3: pending lines visible, enable off so no take
    @(negedge clk); irq_async = 8'h05;
    @(negedge clk); @(negedge clk);
    rd(5'd13, "R2 pending byte", 32'h0000_0500);
    retire(32'h50, 1'b0);
    rd(5'd12, "R3 enable stays off", 32'd0);

    // R2 two-edge delay, no latching
    irq_async = 8'h20;
    @(negedge clk);
    rd(5'd13, "R2 after one edge", 32'h0000_0500);
    @(negedge clk);
    rd(5'd13, "R2 after two edges", 32'h0000_2000);

    // R8 status write, cause write ignored, unmapped read
    wr(5'd12, 32'd1);
    rd(5'd12, "R8 status write", 32'd1);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, "R8 cause read-only", 32'h0000_2000);
    rd(5'd5, "R8 unmapped reads zero", 32'd0);

    // R4 interrupt entry
    exp_q.push_back(VEC);
    retire(32'h100, 1'b0);
    rd(5'd14, "R4 epc next_pc", 32'h104);
    rd(5'd13, "R4 cause code 0", 32'h0000_2000);
    rd(5'd12, "R6 saved enable, enable cleared", 32'h2);

    // R3 no re-entry while handler runs
    retire(32'h80, 1'b0);
    rd(5'd14, "R3 epc unchanged", 32'h104);

    // R7 return
    irq_async = 8'h00;
    exp_q.push_back(32'h104);
    do_eret();
    rd(5'd12, "R7 enable restored", 32'h3);

    // R5 trap wins over pending interrupt
    irq_async = 8'h01;
    @(negedge clk); @(negedge clk);
    exp_q.push_back(VEC);
    retire(32'h200, 1'b1);
    rd(5'd14, "R5 epc faulting pc", 32'h200);
    rd(5'd13, "R5 cause code 12", 32'h0000_0130);
    rd(5'd12, "R6 status after trap", 32'h2);

    // R5 trap taken with enable off
    irq_async = 8'h00;
    exp_q.push_back(VEC);
    retire(32'h300, 1'b1);
    rd(5'd14, "R5 trap with enable off", 32'h300);
    rd(5'd12, "R6 saved enable zero", 32'h0);

    // R9 software write dropped on event cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 5'd14; reg_wr_data = 32'hDEAD;
    instr_valid = 1'b1; trap_ovf = 1'b1; instr_pc = 32'h400; next_pc = 32'h404;
    exp_q.push_back(VEC);
    @(negedge clk);
    reg_wr_en = 1'b0; instr_valid = 1'b0; trap_ovf = 1'b0;
    rd(5'd14, "R9 write dropped", 32'h400);

    // R7 return to software-written address
    wr(5'd14, 32'h1234);
    rd(5'd14, "R8 epc write", 32'h1234);
    exp_q.push_back(32'h1234);
    do_eret();
    rd(5'd12, "R7 enable from saved zero", 32'h0);

    @(negedge clk); @(negedge clk);
    chk("R6/R7 all redirects seen", exp_q.size(), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule